// File: doc/BRIEF.md
# Interval-Comparison Random Bit Extractor

This block draws random bits from the timing of a detector's event pulses. It measures two back-to-back gaps between events in clock cycles and compares them. A shorter first gap yields a one. A longer first gap yields a zero. Equal gaps give no bit, so a further group of three events must be spent to obtain that bit.

The event input is asynchronous. It is brought into the clock domain and reduced to a single-cycle strobe per rising edge. A three-state sequencer walks through the states idle, first-gap and second-gap. It drives a datapath that holds two saturating interval timers and a most-significant-first magnitude comparator. Each accepted bit appears with a one-cycle valid strobe. A downstream collector would gather these bits into wider words.

Top module: `interval_rbit_top`

## Requirements
- R1: Each rising edge of `event_async` produces exactly one high cycle on `event_seen`, however long the input stays high. Edges on the input must be at least three clock cycles apart.
- R2: The sequence repeats every three events. The first event starts the first-gap timer. The second event stops it and starts the second-gap timer. The third event stops the second timer, triggers the comparison and returns the block to idle with both timers at zero.
- R3: If the first gap has fewer counted cycles than the second, `rand_bit` is 1 when `bit_valid` is high. A gap of G cycles between consecutive event edges counts G-1.
- R4: If the first gap has more counted cycles than the second, `rand_bit` is 0 when `bit_valid` is high.
- R5: If the two counts are equal, `bit_valid` stays low for that group of three events.
- R6: Each timer saturates at its maximum (255 at the default width) and does not wrap. Two long gaps therefore compare as a tie, and a long gap against a short one orders correctly.
- R7: `bit_valid` is high for exactly one clock cycle. That cycle is the one right after the cycle in which `event_seen` marks the third event.
- R8: Asserting `rst_n` low clears the sequencer and both timers. The next event after reset is treated as the first event of a new group.
- R9: The comparison is a full magnitude compare, scanning from the most significant bit down. For example, counts 128 versus 127 give 0, and counts 127 versus 128 give 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that the interval timers count |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_async | input | 1 | Unsynchronized detector event pulse |
| rand_bit | output | 1 | Extracted bit, meaningful when `bit_valid` is high |
| bit_valid | output | 1 | One-cycle strobe marking a new bit |
| event_seen | output | 1 | One-cycle strobe per detected event |

## Verification
The bench builds the block with its defaults: 8-bit timers and a two-stage synchronizer. At that width, gaps of a few hundred cycles drive both timers into saturation, so ties caused by saturation and saturated-versus-short orderings are reachable in a short run. The same width makes the 128/127 pair a true most-significant-bit decision. Held event inputs, a reset in the middle of a group, and exact ties are driven alongside ordinary short and long gaps.

// File: rtl/interval_rbit_pkg.sv
package interval_rbit_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_GAP_A = 2'd1,
    PH_GAP_B = 2'd2
  } seqPhase_t;

  typedef struct packed {
    logic runA;
    logic runB;
    logic doCompare;
  } seqCtl_t;
endpackage

// File: rtl/interval_rbit_ctrl.sv
module interval_rbit_ctrl
  import interval_rbit_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    eventAsync,
  output logic    eventPulse,
  output seqCtl_t ctl
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncLast;
  logic                   syncPrev;
  seqPhase_t              phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncChain <= '0;
      syncPrev  <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], eventAsync};
      syncPrev  <= syncChain[SYNC_STAGES-1];
    end
  end

  assign syncLast   = syncChain[SYNC_STAGES-1];
  assign eventPulse = syncLast & ~syncPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else if (eventPulse) begin
      unique case (phase)
        PH_IDLE:  phase <= PH_GAP_A;
        PH_GAP_A: phase <= PH_GAP_B;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.runA      = (phase == PH_GAP_A) && !eventPulse;
    ctl.runB      = (phase == PH_GAP_B) && !eventPulse;
    ctl.doCompare = (phase == PH_GAP_B) && eventPulse;
  end

  // R1: an edge strobe never lasts two cycles
  p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    eventPulse |=> !eventPulse);

  // R2: the third event returns the sequencer to idle
  p_cycle_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GAP_B && eventPulse) |=> (phase == PH_IDLE));

  // R2: timers never run together
  p_one_timer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.runA, ctl.runB, ctl.doCompare}));
endmodule

// File: rtl/interval_rbit_dp.sv
module interval_rbit_dp
  import interval_rbit_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  seqCtl_t ctl,
  output logic    randBit,
  output logic    bitValid
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] timerA;
  logic [CNT_W-1:0] timerB;
  logic             aLess;
  logic             aMore;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timerA <= '0;
      timerB <= '0;
    end else if (ctl.doCompare) begin
      timerA <= '0;
      timerB <= '0;
    end else begin
      if (ctl.runA && timerA != CNT_MAX) timerA <= timerA + 1'b1;
      if (ctl.runB && timerB != CNT_MAX) timerB <= timerB + 1'b1;
    end
  end

  // magnitude compare, most significant bit decides first
  always_comb begin
    logic decided;
    decided = 1'b0;
    aLess   = 1'b0;
    aMore   = 1'b0;
    for (int i = CNT_W - 1; i >= 0; i--) begin
      if (!decided && (timerA[i] != timerB[i])) begin
        decided = 1'b1;
        aLess   = timerB[i];
        aMore   = timerA[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      randBit  <= 1'b0;
      bitValid <= 1'b0;
    end else begin
      bitValid <= ctl.doCompare && (aLess || aMore);
      if (ctl.doCompare && (aLess || aMore)) randBit <= aLess;
    end
  end

  // R7: valid is a single-cycle strobe
  p_valid_one_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bitValid |=> !bitValid);

  // R6: a saturated timer that keeps running holds its value
  p_sat_hold_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (timerA == CNT_MAX && ctl.runA) |=> (timerA == CNT_MAX));
  p_sat_hold_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (timerB == CNT_MAX && ctl.runB) |=> (timerB == CNT_MAX));

  // R2: comparison leaves both timers cleared
  p_clear_after_cmp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.doCompare |=> (timerA == '0 && timerB == '0));

  // R5: equal counts never raise valid
  p_tie_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.doCompare && timerA == timerB) |=> !bitValid);

  // R3: a smaller first count gives a one
  p_less_gives_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.doCompare && timerA < timerB) |=> (bitValid && randBit));

  // R4: a larger first count gives a zero
  p_more_gives_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.doCompare && timerA > timerB) |=> (bitValid && !randBit));
endmodule

// File: rtl/interval_rbit_top.sv
module interval_rbit_top
  import interval_rbit_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic event_async,
  output logic rand_bit,
  output logic bit_valid,
  output logic event_seen
);
  seqCtl_t seqCtl;

  interval_rbit_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .eventAsync (event_async),
    .eventPulse (event_seen),
    .ctl        (seqCtl)
  );

  interval_rbit_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (seqCtl),
    .randBit  (rand_bit),
    .bitValid (bit_valid)
  );

  // R7: valid follows an event strobe by one cycle
  p_valid_after_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_valid) |-> $past(event_seen));
endmodule

// File: tb/interval_rbit_top_tb.sv
module interval_rbit_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic event_async = 1'b0;
  logic rand_bit, bit_valid, event_seen;

  int testsRun = 0;
  int testsFailed = 0;
  int eventsSent = 0;
  int eventsSeen = 0;
  logic  expBits[$];
  string expTags[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_rbit_top #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .event_async (event_async),
    .rand_bit    (rand_bit),
    .bit_valid   (bit_valid),
    .event_seen  (event_seen)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  logic prevValid = 1'b0;
  logic prevSeen  = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (event_seen) eventsSeen++;
      if (bit_valid) begin
        check(!prevValid, "R7 valid width", 1, 0);
        check(prevSeen, "R7 valid timing", 0, 1);
        if (expBits.size() == 0) begin
          check(1'b0, "R5 unexpected bit", 1, 0);
        end else begin
          logic  e;
          string t;
          e = expBits.pop_front();
          t = expTags.pop_front();
          check(rand_bit == e, t, rand_bit, e);
        end
      end
    end
    prevValid = bit_valid;
    prevSeen  = event_seen;
  end

  task automatic pulseEvt(input int hold);
    event_async = 1'b1;
    repeat (hold) @(negedge clk);
    event_async = 1'b0;
    eventsSent++;
  endtask

  function automatic int satCount(input int gap);
    return (gap - 1 > CNT_MAX) ? CNT_MAX : gap - 1;
  endfunction

  task automatic sendTriple(input int g1, input int g2, input int hold, input string tag);
    int a, b;
    a = satCount(g1);
    b = satCount(g2);
    if (a != b) begin
      expBits.push_back(a < b);
      expTags.push_back(tag);
    end
    pulseEvt(hold);
    repeat (g1 - hold) @(negedge clk);
    pulseEvt(2);
    repeat (g2 - 2) @(negedge clk);
    pulseEvt(2);
    repeat (8) @(negedge clk);
    check(expBits.size() == 0, {tag, " drained"}, expBits.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bit_valid == 1'b0, "R8 reset valid", bit_valid, 0);
    check(event_seen == 1'b0, "R8 reset event", event_seen, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    sendTriple(10, 20, 2, "R3 short first");
    sendTriple(20, 10, 2, "R4 long first");
    sendTriple(15, 15, 2, "R5 tie");
    sendTriple(129, 128, 2, "R9 128 vs 127");
    sendTriple(128, 129, 2, "R9 127 vs 128");
    sendTriple(300, 400, 2, "R6 both saturated tie");
    sendTriple(300, 100, 2, "R6 saturated first");
    sendTriple(50, 600, 2, "R6 saturated second");
    sendTriple(40, 30, 20, "R1 held event");
    check(eventsSeen == eventsSent, "R1 event count", eventsSeen, eventsSent);
    sendTriple(5, 5, 2, "R2 tie then recover");
    sendTriple(6, 4, 2, "R2 next group");

    // R8: reset in the middle of a group
    pulseEvt(2);
    repeat (10) @(negedge clk);
    pulseEvt(2);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(bit_valid == 1'b0, "R8 valid in reset", bit_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    sendTriple(5, 9, 2, "R8 after reset");
    sendTriple(9, 5, 2, "R8 second after reset");

    check(expBits.size() == 0, "R2 final queue", expBits.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule